// File: doc/BRIEF.md
# Event Timestamp Capture Unit

This block records when an external event happens. It compares the timestamp with a free-running counter that it receives as an input. One of two single-bit sources is chosen: a device pin or the output of an on-chip comparator. The chosen source is synchronized and can optionally be passed through a majority-free glitch filter. An edge detector then decides whether the change counts as an event. On each qualifying edge the counter value is loaded into a capture register and a capture flag is raised. When interrupts are enabled, the flag drives an interrupt request.

Software reads the capture value over a byte-wide bus. It reads the low byte first. That read saves the matching high byte in a holding register, so the following high-byte read returns a value that belongs to the same capture, even if a newer capture has arrived in between. The flag is cleared when the interrupt is acknowledged, or when software writes a one to the flag bit.

Top module: `evcap_unit`

## Requirements
- R1: `src_sel_i` = 0 selects `pin_i` and `src_sel_i` = 1 selects `cmp_i`. Edges on the unselected input never cause a capture.
- R2: `edge_rise_i` = 1 makes only a 0-to-1 change an event. `edge_rise_i` = 0 makes only a 1-to-0 change an event. A change in the other direction causes no capture.
- R3: With the filter off, take an input change that is set up before rising clock edge k. The capture register loads the `count_i` value sampled at edge k+2, and nothing is captured earlier.
- R4: With `filt_en_i` = 1, the filtered level follows the synchronized level only after FILT_LEN (4) equal consecutive samples. This delays a capture by exactly 4 cycles compared with R3, and a pulse held for 3 cycles or fewer is discarded.
- R5: The capture flag is set on the same clock edge on which the capture register is loaded.
- R6: `irq_o` is high exactly when the flag is set and `irq_en_i` = 1.
- R7: A high `irq_ack_i` clears the flag at the next clock edge.
- R8: Writing a byte whose bit 0 is 1 to address 2 clears the flag. Writing a byte whose bit 0 is 0 to address 2 leaves the flag unchanged. A read of address 2 returns the flag in bit 0 and zeros in bits 7:1.
- R9: A read of address 0 returns capture bits 7:0 and copies capture bits 15:8 into the holding register. A read of address 1 returns the holding register. The holding register is unaffected by later captures until the next address-0 read.
- R10: A capture while the flag is already set overwrites the capture register with the newer value, and the flag stays set.
- R11: When a capture and a flag clear (write or acknowledge) fall on the same clock edge, the flag ends up set.
- R12: After reset the flag, the capture register, the holding register and `irq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | External event pin (asynchronous) |
| cmp_i | input | 1 | Comparator output event source (asynchronous) |
| src_sel_i | input | 1 | Source select: 0 pin, 1 comparator |
| edge_rise_i | input | 1 | Edge select: 1 rising, 0 falling |
| filt_en_i | input | 1 | Glitch filter enable |
| irq_en_i | input | 1 | Interrupt enable |
| count_i | input | CNT_W | Free-running counter value to timestamp |
| addr_i | input | 2 | Bus address: 0 low byte, 1 held high byte, 2 flag |
| rd_i | input | 1 | Bus read strobe |
| wr_i | input | 1 | Bus write strobe |
| wdata_i | input | BUS_W | Bus write data |
| rdata_o | output | BUS_W | Bus read data (combinational on address) |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the unit with its defaults: a 16-bit counter, an 8-bit bus, two synchronizer stages and a four-sample filter that is present. The bench counter advances by 0x0123 per cycle, so both bytes change on every edge and a timestamp that is off by even one cycle shows up in either byte. With the filter present, the exact four-cycle extra latency and the rejection of a three-cycle pulse can both be measured. The byte-wide bus makes the holding-register behaviour across an intervening capture observable.

// File: rtl/evcap_pkg.sv
package evcap_pkg;

   // Bus register addresses
   typedef enum logic [1:0] {
      ADDR_CAP_LO = 2'd0,
      ADDR_CAP_HI = 2'd1,
      ADDR_FLAG   = 2'd2
   } evcap_addr_e;

   localparam int unsigned FLAG_BIT = 0;

endpackage

// File: rtl/evcap_sync.sv
module evcap_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("evcap_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] st_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q <= '0;
      end else begin
         st_q[0] <= d_i;
         for (int i = 1; i < int'(STAGES); i++) begin
            st_q[i] <= st_q[i-1];
         end
      end
   end

   assign q_o = st_q[STAGES-1];

endmodule

// File: rtl/evcap_filter.sv
module evcap_filter #(
   parameter int unsigned LEN     = 4,
   parameter bit          PRESENT = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic d_i,
   output logic q_o
);

   if (LEN < 2) begin : g_bad_len
      $error("evcap_filter: LEN must be at least 2");
   end

   if (PRESENT) begin : g_filter
      // Current sample plus LEN-1 stored samples form the vote window
      logic [LEN-2:0] hist_q;
      logic [LEN-1:0] window;
      logic           filt_q;

      assign window = {hist_q, d_i};

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            hist_q <= '0;
            filt_q <= 1'b0;
         end else begin
            hist_q[0] <= d_i;
            for (int i = 1; i < int'(LEN) - 1; i++) begin
               hist_q[i] <= hist_q[i-1];
            end
            // Level tracked even while bypassed, so enabling it is glitch free
            if (&window) begin
               filt_q <= 1'b1;
            end else if (~|window) begin
               filt_q <= 1'b0;
            end
         end
      end

      assign q_o = en_i ? filt_q : d_i;
   end else begin : g_bypass
      logic unused_filt;
      assign unused_filt = en_i ^ clk_i ^ rst_ni;
      assign q_o = d_i;
   end

endmodule

// File: rtl/evcap_edge.sv
module evcap_edge (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lvl_i,
   input  logic rise_sel_i,
   output logic evt_o
);

   logic prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= 1'b0;
      end else begin
         prev_q <= lvl_i;
      end
   end

   assign evt_o = rise_sel_i ? (lvl_i & ~prev_q) : (~lvl_i & prev_q);

endmodule

// File: rtl/evcap_unit.sv
module evcap_unit
   import evcap_pkg::*;
#(
   parameter int unsigned CNT_W          = 16,
   parameter int unsigned BUS_W          = 8,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned FILT_LEN       = 4,
   parameter bit          FILTER_PRESENT = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             pin_i,
   input  logic             cmp_i,
   input  logic             src_sel_i,
   input  logic             edge_rise_i,
   input  logic             filt_en_i,
   input  logic             irq_en_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic [1:0]       addr_i,
   input  logic             rd_i,
   input  logic             wr_i,
   input  logic [BUS_W-1:0] wdata_i,
   output logic [BUS_W-1:0] rdata_o,
   input  logic             irq_ack_i,
   output logic             irq_o
);

   localparam int unsigned HI_W = CNT_W - BUS_W;

   if (CNT_W != 2 * BUS_W) begin : g_bad_width
      $error("evcap_unit: CNT_W must be twice BUS_W");
   end
   if (BUS_W < 2) begin : g_bad_bus
      $error("evcap_unit: BUS_W must be at least 2");
   end

   logic             src_lvl;
   logic             sync_lvl;
   logic             filt_lvl;
   logic             cap_evt;
   logic [CNT_W-1:0] cap_q;
   logic [HI_W-1:0]  temp_q;
   logic             flag_q;
   logic             flag_clr;
   logic             lo_rd;
   logic             unused_wdata;

   // Source selection ahead of the synchronizer
   assign src_lvl = src_sel_i ? cmp_i : pin_i;

   evcap_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (src_lvl),
      .q_o    (sync_lvl)
   );

   evcap_filter #(
      .LEN     (FILT_LEN),
      .PRESENT (FILTER_PRESENT)
   ) u_filter (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (filt_en_i),
      .d_i    (sync_lvl),
      .q_o    (filt_lvl)
   );

   evcap_edge u_edge (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .lvl_i      (filt_lvl),
      .rise_sel_i (edge_rise_i),
      .evt_o      (cap_evt)
   );

   assign flag_clr = irq_ack_i
                   | (wr_i && (addr_i == ADDR_FLAG) && wdata_i[FLAG_BIT]);
   assign lo_rd    = rd_i && (addr_i == ADDR_CAP_LO);
   assign unused_wdata = ^wdata_i;

   // Capture register and flag; a new capture outranks any clear
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cap_q  <= '0;
         flag_q <= 1'b0;
      end else if (cap_evt) begin
         cap_q  <= count_i;
         flag_q <= 1'b1;
      end else if (flag_clr) begin
         flag_q <= 1'b0;
      end
   end

   // High byte held on the low-byte read for an atomic pair
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         temp_q <= '0;
      end else if (lo_rd) begin
         temp_q <= cap_q[CNT_W-1:BUS_W];
      end
   end

   always_comb begin
      unique case (addr_i)
         ADDR_CAP_LO: rdata_o = cap_q[BUS_W-1:0];
         ADDR_CAP_HI: rdata_o = BUS_W'(temp_q);
         ADDR_FLAG:   rdata_o = BUS_W'(flag_q);
         default:     rdata_o = '0;
      endcase
   end

   assign irq_o = flag_q & irq_en_i;

endmodule

// File: rtl/evcap_unit_chk.sv
module evcap_unit_chk
   import evcap_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned BUS_W = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             irq_o,
   input logic             irq_en_i,
   input logic             irq_ack_i,
   input logic             rd_i,
   input logic             wr_i,
   input logic [1:0]       addr_i,
   input logic [BUS_W-1:0] wdata_i,
   input logic [CNT_W-1:0] count_i,
   input logic             cap_evt,
   input logic [CNT_W-1:0] cap_q,
   input logic             flag_q,
   input logic [CNT_W-BUS_W-1:0] temp_q
);

   assert_cap_value_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_evt |=> (cap_q == $past(count_i)));

   assert_flag_with_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(cap_q) |-> flag_q);

   assert_irq_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (irq_en_i && flag_q));

   assert_ack_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_ack_i && !cap_evt) |=> !flag_q);

   assert_zero_write_keeps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q && wr_i && addr_i == ADDR_FLAG && !wdata_i[FLAG_BIT] && !irq_ack_i)
      |=> flag_q);

   assert_temp_latch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && addr_i == ADDR_CAP_LO) |=> (temp_q == $past(cap_q[CNT_W-1:BUS_W])));

   assert_capture_beats_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_evt |=> flag_q);

endmodule

bind evcap_unit evcap_unit_chk #(
   .CNT_W (CNT_W),
   .BUS_W (BUS_W)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .irq_o     (irq_o),
   .irq_en_i  (irq_en_i),
   .irq_ack_i (irq_ack_i),
   .rd_i      (rd_i),
   .wr_i      (wr_i),
   .addr_i    (addr_i),
   .wdata_i   (wdata_i),
   .count_i   (count_i),
   .cap_evt   (cap_evt),
   .cap_q     (cap_q),
   .flag_q    (flag_q),
   .temp_q    (temp_q)
);

// File: tb/evcap_unit_bench.sv
`timescale 1ns/1ps
module evcap_unit_bench;

   localparam logic [15:0] STEP = 16'h0123;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pin = 1'b0, cmp = 1'b0;
   logic        src = 1'b0, rise = 1'b1, fen = 1'b0, ien = 1'b0;
   logic [15:0] cnt;
   logic [1:0]  addr = 2'd0;
   logic        rd = 1'b0, wr = 1'b0, ack = 1'b0;
   logic [7:0]  wdata = 8'h00;
   logic [7:0]  rdata;
   logic        irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) cnt <= 16'h1000;
      else        cnt <= cnt + STEP;
   end

   evcap_unit u_evcap_unit (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .pin_i       (pin),
      .cmp_i       (cmp),
      .src_sel_i   (src),
      .edge_rise_i (rise),
      .filt_en_i   (fen),
      .irq_en_i    (ien),
      .count_i     (cnt),
      .addr_i      (addr),
      .rd_i        (rd),
      .wr_i        (wr),
      .wdata_i     (wdata),
      .rdata_o     (rdata),
      .irq_ack_i   (ack),
      .irq_o       (irq)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Bus read starting at the current falling edge
   task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
      addr = a; rd = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      addr = a; wr = 1'b1; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic pulse_ack();
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
   endtask

   task automatic read_cap(input string req, input logic [15:0] exp);
      logic [7:0] lo, hi;
      bus_rd(2'd0, lo);
      bus_rd(2'd1, hi);
      check(req, {hi, lo}, exp);
   endtask

   // Change a source at a falling edge, check irq one cycle before and at capture
   task automatic fire(input bit use_cmp, input logic val, input int extra,
                       input bit pre_chk, input string req, output logic [15:0] exp);
      logic [15:0] c0;
      if (use_cmp) cmp = val; else pin = val;
      c0  = cnt;
      exp = c0 + STEP * 16'(2 + extra);
      repeat (2 + extra) @(negedge clk);
      if (pre_chk) check({req, " no early capture"}, 16'(irq), 16'd0);
      @(negedge clk);
      check({req, " flag at capture edge (R5)"}, 16'(irq), 16'd1);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check("R12 irq after reset", 16'(irq), 16'd0);
      bus_rd(2'd2, d); check("R12 flag after reset", 16'(d), 16'd0);
      bus_rd(2'd0, d); check("R12 low byte after reset", 16'(d), 16'd0);
      bus_rd(2'd1, d); check("R12 held byte after reset", 16'(d), 16'd0);
   endtask

   task automatic t_rising_pin();
      logic [15:0] e;
      src = 1'b0; rise = 1'b1; ien = 1'b1;
      @(negedge clk);
      fire(1'b0, 1'b1, 0, 1'b1, "R3", e);
      read_cap("R3 R9 pin rise timestamp", e);
   endtask

   task automatic t_irq_gate();
      logic [7:0] d;
      ien = 1'b0; #1 check("R6 irq masked", 16'(irq), 16'd0);
      ien = 1'b1; #1 check("R6 irq enabled", 16'(irq), 16'd1);
      @(negedge clk);
      pulse_ack();
      check("R7 irq after ack", 16'(irq), 16'd0);
      bus_rd(2'd2, d); check("R7 flag after ack", 16'(d), 16'd0);
   endtask

   task automatic t_falling();
      logic [15:0] e;
      rise = 1'b0;
      repeat (4) @(negedge clk);
      fire(1'b0, 1'b0, 0, 1'b1, "R2 fall", e);
      read_cap("R2 fall timestamp", e);
      pulse_ack();
      pin = 1'b1;
      repeat (10) @(negedge clk);
      check("R2 rising ignored under fall select", 16'(irq), 16'd0);
   endtask

   task automatic t_source();
      logic [15:0] e;
      src = 1'b1; rise = 1'b1;
      repeat (6) @(negedge clk);
      pulse_ack();
      pin = 1'b0; repeat (6) @(negedge clk);
      pin = 1'b1; repeat (10) @(negedge clk);
      check("R1 unselected pin ignored", 16'(irq), 16'd0);
      fire(1'b1, 1'b1, 0, 1'b1, "R1 comparator", e);
      read_cap("R1 comparator timestamp", e);
   endtask

   task automatic t_filter();
      logic [15:0] e;
      pulse_ack();
      fen = 1'b1;
      cmp = 1'b0; repeat (12) @(negedge clk);
      cmp = 1'b1; repeat (3) @(negedge clk);
      cmp = 1'b0; repeat (12) @(negedge clk);
      check("R4 short pulse discarded", 16'(irq), 16'd0);
      fire(1'b1, 1'b1, 4, 1'b1, "R4 filtered", e);
      read_cap("R4 filtered timestamp", e);
   endtask

   task automatic t_write_clear();
      logic [7:0] d;
      bus_wr(2'd2, 8'hFE);
      bus_rd(2'd2, d); check("R8 zero write keeps flag", 16'(d), 16'd1);
      bus_wr(2'd2, 8'h01);
      bus_rd(2'd2, d); check("R8 one write clears flag", 16'(d), 16'd0);
      check("R8 irq after clear", 16'(irq), 16'd0);
   endtask

   task automatic t_overwrite();
      logic [15:0] e1, e2;
      logic [7:0]  d;
      fen = 1'b0;
      cmp = 1'b0; repeat (8) @(negedge clk);
      fire(1'b1, 1'b1, 0, 1'b1, "R10 first", e1);
      cmp = 1'b0; repeat (8) @(negedge clk);
      fire(1'b1, 1'b1, 0, 1'b0, "R10 second", e2);
      read_cap("R10 newer value kept", e2);
      bus_rd(2'd2, d); check("R10 flag stays set", 16'(d), 16'd1);
   endtask

   task automatic t_temp_hold();
      logic [15:0] e;
      logic [7:0]  d, old_hi;
      bus_rd(2'd0, d);
      bus_rd(2'd1, old_hi);
      bus_rd(2'd0, d);
      cmp = 1'b0; repeat (8) @(negedge clk);
      fire(1'b1, 1'b1, 0, 1'b0, "R9 recapture", e);
      bus_rd(2'd1, d); check("R9 held byte survives capture", 16'(d), 16'(old_hi));
      read_cap("R9 fresh pair", e);
   endtask

   task automatic t_race();
      logic [15:0] c0;
      logic [7:0]  d;
      cmp = 1'b0; repeat (8) @(negedge clk);
      cmp = 1'b1; c0 = cnt;
      repeat (2) @(negedge clk);
      addr = 2'd2; wdata = 8'h01; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
      bus_rd(2'd2, d); check("R11 capture beats clear", 16'(d), 16'd1);
      read_cap("R11 value of racing capture", c0 + STEP * 16'd2);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rising_pin();
      t_irq_gate();
      t_falling();
      t_source();
      t_filter();
      t_write_clear();
      t_overwrite();
      t_temp_hold();
      t_race();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog (all requirements): actual hung expected finished");
         summary();
         $finish;
      end
   end

endmodule